// File: doc/BRIEF.md
# Clock Root Staged Configuration Controller

This block is the control side of one clock root. Software writes a source select, a pre-divider, a mode, a hardware clock-control flag and three fraction values (M, N, D) into staged registers through a small word-addressed register port. None of these writes reach the divider that the block drives. The staged values move into the active configuration outputs together, and only after software sets a commit bit in the command register. The hardware clears that bit when the copy has been made, so software can poll for the end of the commit.

The command register also holds a force-on bit, which keeps the root running while it is being reprogrammed. It holds a read-only root-off flag, which is 1 only when neither the force-on bit nor the external enable request is asserted. Four per-register dirty flags show which staged registers have been written since the last commit. Word addresses are: command 0, configuration 1, M 2, N 3, D 4. Other addresses read zero and ignore writes. The pre-divider width parameter must not exceed 8, so that the field stays below the source select.

Top module: `clk_root_ctrl`

## Requirements
- R1: After reset, all staged and active fields are zero, no commit is pending, the root-off output is 1 and the command register (address 0) reads 0x8000_0000.
- R2: Writes to the configuration (address 1), M (2), N (3) or D (4) registers never change the active outputs without a commit. The configuration register reads back only its defined fields: pre-divider in bits DIV_W-1:0, source select in bits 10:8, mode in bits 13:12, hardware clock-control in bit 20; all other bits read 0. M, N and D read back their low MND_W bits.
- R3: Writing 1 to command bit 0 sets that bit (pending). Exactly 2 clock edges after the capturing edge, every active field takes its staged value in the same cycle, and bit 0 reads 0 again.
- R4: A commit request made while a commit is pending is ignored. The pending commit still completes on its original schedule, and no second commit follows it.
- R5: Command bits 4, 5, 6 and 7 are dirty flags for configuration, N, M and D respectively. Each is set by a write to its register and cleared when a commit completes.
- R6: Command bit 1 is a read/write force-on bit. When it or the enable request input is 1, the root-off flag (command bit 31 and the root-off output) reads 0 one cycle later.
- R7: When neither the force-on bit nor the enable request input is 1, the root-off flag reads 1 one cycle later.
- R8: Writing 0 to command bit 0 while a commit is pending does not cancel it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| en_req_i | input | 1 | External enable request for the root |
| act_div_o | output | DIV_W | Active pre-divider |
| act_src_o | output | 3 | Active source select |
| act_mode_o | output | 2 | Active mode |
| act_hwctl_o | output | 1 | Active hardware clock-control flag |
| act_m_o | output | MND_W | Active M value |
| act_n_o | output | MND_W | Active N value |
| act_d_o | output | MND_W | Active D value |
| root_off_o | output | 1 | 1 while the root is off |

## Verification
The staging path is driven with random field values, random garbage in undefined bits, and random subsets of written registers. Each round shows that the active outputs hold until a commit, that undefined bits are dropped, and that the dirty flags match the written subset. Directed sequences place a second commit request, and separately a write of 0, on the cycle after a commit starts. These separate a correct single commit from one that restarts, is cancelled or gets queued; a later staged write that must stay inactive exposes a queued commit. The force-on bit and the enable request are toggled one at a time, to tell the OR of the two apart from either one alone.

// File: rtl/clk_root_pkg.sv
package clk_root_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 32;
  localparam int SRC_W  = 3;
  localparam int MODE_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_CMD = 3'd0,
    REG_CFG = 3'd1,
    REG_M   = 3'd2,
    REG_N   = 3'd3,
    REG_D   = 3'd4
  } reg_sel_e;

  localparam int CMD_COMMIT_BIT = 0;
  localparam int CMD_FORCE_BIT  = 1;
  localparam int CMD_DIRTY_LSB  = 4;
  localparam int CMD_OFF_BIT    = 31;

  localparam int CFG_SRC_LSB  = 8;
  localparam int CFG_MODE_LSB = 12;
  localparam int CFG_HW_BIT   = 20;

  // dirty vector index: 0 cfg, 1 n, 2 m, 3 d
  localparam int DIRTY_W = 4;

  // fraction register k: 0 m, 1 n, 2 d
  function automatic reg_sel_e mnd_addr(input int k);
    case (k)
      0:       return REG_M;
      1:       return REG_N;
      default: return REG_D;
    endcase
  endfunction

  function automatic int mnd_dirty_idx(input int k);
    case (k)
      0:       return 2;
      1:       return 1;
      default: return 3;
    endcase
  endfunction
endpackage

// File: rtl/clk_root_regs.sv
module clk_root_regs
  import clk_root_pkg::*;
#(
  parameter int DIV_W = 5,
  parameter int MND_W = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [DATA_W-1:0]            wdata_i,
  input  logic                         commit_done_i,
  output logic [DIV_W-1:0]             st_div_o,
  output logic [SRC_W-1:0]             st_src_o,
  output logic [MODE_W-1:0]            st_mode_o,
  output logic                         st_hw_o,
  output logic [2:0][MND_W-1:0]        st_mnd_o,
  output logic                         force_en_o,
  output logic [DIRTY_W-1:0]           dirty_o
);
  logic [DIRTY_W-1:0] dirty_set;
  logic               wr_cfg, wr_cmd;

  assign wr_cfg = we_i && (addr_i == REG_CFG);
  assign wr_cmd = we_i && (addr_i == REG_CMD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_div_o  <= '0;
      st_src_o  <= '0;
      st_mode_o <= '0;
      st_hw_o   <= 1'b0;
    end else if (wr_cfg) begin
      st_div_o  <= wdata_i[DIV_W-1:0];
      st_src_o  <= wdata_i[CFG_SRC_LSB +: SRC_W];
      st_mode_o <= wdata_i[CFG_MODE_LSB +: MODE_W];
      st_hw_o   <= wdata_i[CFG_HW_BIT];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     force_en_o <= 1'b0;
    else if (wr_cmd) force_en_o <= wdata_i[CMD_FORCE_BIT];
  end

  assign dirty_set[0] = wr_cfg;

  for (genvar k = 0; k < 3; k++) begin : g_mnd
    localparam reg_sel_e KADDR = mnd_addr(k);
    localparam int       KDIRT = mnd_dirty_idx(k);
    logic wr_k;
    assign wr_k = we_i && (addr_i == KADDR);
    assign dirty_set[KDIRT] = wr_k;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   st_mnd_o[k] <= '0;
      else if (wr_k) st_mnd_o[k] <= wdata_i[MND_W-1:0];
    end
  end

  for (genvar i = 0; i < DIRTY_W; i++) begin : g_dirty
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                dirty_o[i] <= 1'b0;
      else if (dirty_set[i])      dirty_o[i] <= 1'b1;
      else if (commit_done_i)     dirty_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/clk_root_commit.sv
module clk_root_commit #(
  parameter int LAT = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic pending_o,
  output logic done_o
);
  localparam int CW = (LAT < 2) ? 1 : $clog2(LAT + 1);
  logic [CW-1:0] cnt_q;

  assign done_o = pending_o && (cnt_q == CW'(LAT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_o <= 1'b0;
      cnt_q     <= '0;
    end else if (req_i && !pending_o) begin
      pending_o <= 1'b1;
      cnt_q     <= '0;
    end else if (done_o) begin
      pending_o <= 1'b0;
      cnt_q     <= '0;
    end else if (pending_o) begin
      cnt_q     <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/clk_root_active.sv
module clk_root_active #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/clk_root_status.sv
module clk_root_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic force_en_i,
  input  logic en_req_i,
  output logic root_off_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) root_off_o <= 1'b1;
    else         root_off_o <= !(force_en_i || en_req_i);
  end
endmodule

// File: rtl/clk_root_ctrl.sv
module clk_root_ctrl
  import clk_root_pkg::*;
#(
  parameter int DIV_W      = 5,
  parameter int MND_W      = 8,
  parameter int COMMIT_LAT = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [2:0]         addr_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  input  logic               en_req_i,
  output logic [DIV_W-1:0]   act_div_o,
  output logic [2:0]         act_src_o,
  output logic [1:0]         act_mode_o,
  output logic               act_hwctl_o,
  output logic [MND_W-1:0]   act_m_o,
  output logic [MND_W-1:0]   act_n_o,
  output logic [MND_W-1:0]   act_d_o,
  output logic               root_off_o
);
  localparam int ACT_W = DIV_W + SRC_W + MODE_W + 1 + 3 * MND_W;

  logic [DIV_W-1:0]      st_div;
  logic [SRC_W-1:0]      st_src;
  logic [MODE_W-1:0]     st_mode;
  logic                  st_hw;
  logic [2:0][MND_W-1:0] st_mnd;
  logic                  force_en;
  logic [DIRTY_W-1:0]    dirty;
  logic                  commit_req, commit_pending, commit_done;
  logic [ACT_W-1:0]      st_bus, act_q;

  assign commit_req = we_i && (addr_i == REG_CMD) && wdata_i[CMD_COMMIT_BIT];

  clk_root_regs #(.DIV_W(DIV_W), .MND_W(MND_W)) u_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .commit_done_i(commit_done),
    .st_div_o(st_div), .st_src_o(st_src), .st_mode_o(st_mode),
    .st_hw_o(st_hw), .st_mnd_o(st_mnd),
    .force_en_o(force_en), .dirty_o(dirty)
  );

  clk_root_commit #(.LAT(COMMIT_LAT)) u_commit (
    .clk_i, .rst_ni, .req_i(commit_req),
    .pending_o(commit_pending), .done_o(commit_done)
  );

  assign st_bus = {st_hw, st_mode, st_src, st_div, st_mnd[2], st_mnd[1], st_mnd[0]};

  clk_root_active #(.W(ACT_W)) u_active (
    .clk_i, .rst_ni, .load_i(commit_done), .d_i(st_bus), .q_o(act_q)
  );

  assign {act_hwctl_o, act_mode_o, act_src_o, act_div_o, act_d_o, act_n_o, act_m_o} = act_q;

  clk_root_status u_status (
    .clk_i, .rst_ni, .force_en_i(force_en), .en_req_i, .root_off_o
  );

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      REG_CMD: begin
        rdata_o[CMD_COMMIT_BIT]                = commit_pending;
        rdata_o[CMD_FORCE_BIT]                 = force_en;
        rdata_o[CMD_DIRTY_LSB +: DIRTY_W]      = dirty;
        rdata_o[CMD_OFF_BIT]                   = root_off_o;
      end
      REG_CFG: begin
        rdata_o[DIV_W-1:0]                     = st_div;
        rdata_o[CFG_SRC_LSB +: SRC_W]          = st_src;
        rdata_o[CFG_MODE_LSB +: MODE_W]        = st_mode;
        rdata_o[CFG_HW_BIT]                    = st_hw;
      end
      REG_M:   rdata_o[MND_W-1:0] = st_mnd[0];
      REG_N:   rdata_o[MND_W-1:0] = st_mnd[1];
      REG_D:   rdata_o[MND_W-1:0] = st_mnd[2];
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/clk_root_ctrl_chk.sv
module clk_root_ctrl_chk #(
  parameter int ACT_W = 30
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             we_i,
  input logic             en_req_i,
  input logic             commit_pending,
  input logic             commit_done,
  input logic             force_en,
  input logic [3:0]       dirty,
  input logic [ACT_W-1:0] act_q,
  input logic             root_off_o
);
  AST_ACTIVE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_done |=> $stable(act_q)); // R2
  AST_DONE_NEEDS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_done |-> commit_pending); // R3
  AST_COMMIT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_done |=> !commit_pending); // R3
  AST_PEND_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_pending && !commit_done |=> commit_pending); // R4
  AST_DIRTY_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_done && !we_i |=> dirty == 4'b0); // R5
  AST_FORCE_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_en |=> !root_off_o); // R6
  AST_IDLE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !force_en && !en_req_i |=> root_off_o); // R7
endmodule

bind clk_root_ctrl clk_root_ctrl_chk #(.ACT_W(ACT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .en_req_i(en_req_i),
  .commit_pending(commit_pending), .commit_done(commit_done),
  .force_en(force_en), .dirty(dirty), .act_q(act_q), .root_off_o(root_off_o)
);

// File: tb/clk_root_ctrl_bench.sv
`timescale 1ns/1ps
module clk_root_ctrl_bench;
  localparam int DIV_W = 5;
  localparam int MND_W = 8;

  logic clk_i = 1'b0, rst_ni = 1'b0, we_i = 1'b0, en_req_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [31:0] wdata_i = '0, rdata_o;
  logic [DIV_W-1:0] act_div_o;
  logic [2:0] act_src_o;
  logic [1:0] act_mode_o;
  logic act_hwctl_o, root_off_o;
  logic [MND_W-1:0] act_m_o, act_n_o, act_d_o;

  int total = 0, bad = 0;
  bit done = 0;
  logic [31:0] exp_cfg, exp_m, exp_n, exp_d;       // staged model
  logic [31:0] act_cfg, act_m, act_n, act_d;       // active model

  always #5 clk_i = ~clk_i;

  clk_root_ctrl #(.DIV_W(DIV_W), .MND_W(MND_W)) u_clk_root_ctrl (.*);

  function automatic logic [31:0] cfg_mask();
    return (32'h1 << 20) | (32'h3 << 12) | (32'h7 << 8) | ((32'h1 << DIV_W) - 1);
  endfunction
  function automatic logic [31:0] mnd_mask();
    return (32'h1 << MND_W) - 1;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] act_cfg_port();
    logic [31:0] w = '0;
    w[DIV_W-1:0] = act_div_o;
    w[10:8] = act_src_o;
    w[13:12] = act_mode_o;
    w[20] = act_hwctl_o;
    return w;
  endfunction

  task automatic chk_act(input string tag);
    chk({tag, " cfg"}, act_cfg_port(), act_cfg);
    chk({tag, " m"}, 32'(act_m_o), act_m);
    chk({tag, " n"}, 32'(act_n_o), act_n);
    chk({tag, " d"}, 32'(act_d_o), act_d);
  endtask

  // drive now (low phase), release at next negedge
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    we_i = 1'b0;
    case (a)
      3'd1: exp_cfg = d & cfg_mask();
      3'd2: exp_m = d & mnd_mask();
      3'd3: exp_n = d & mnd_mask();
      3'd4: exp_d = d & mnd_mask();
      default: ;
    endcase
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr_i = a; #1; d = rdata_o;
    @(negedge clk_i);
  endtask

  task automatic model_commit();
    act_cfg = exp_cfg; act_m = exp_m; act_n = exp_n; act_d = exp_d;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd1234));
    exp_cfg = 0; exp_m = 0; exp_n = 0; exp_d = 0;
    act_cfg = 0; act_m = 0; act_n = 0; act_d = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    chk_act("R1 reset active");
    chk("R1 root_off", 32'(root_off_o), 1);
    rd(3'd0, r); chk("R1 cmd", r, 32'h8000_0000);
    rd(3'd1, r); chk("R1 cfg staged", r, 0);
    rd(3'd4, r); chk("R1 d staged", r, 0);

    // R6 / R7 force-on and enable request
    wr(3'd0, 32'h2);
    chk("R7 off one cycle before", 32'(root_off_o), 1);
    @(negedge clk_i);
    chk("R6 force on", 32'(root_off_o), 0);
    rd(3'd0, r); chk("R6 cmd force", r, 32'h0000_0002);
    wr(3'd0, 32'h0);
    @(negedge clk_i);
    chk("R7 force cleared", 32'(root_off_o), 1);
    en_req_i = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i);
    chk("R6 en_req on", 32'(root_off_o), 0);
    rd(3'd0, r); chk("R6 cmd bit31", r, 32'h0);
    en_req_i = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
    chk("R7 idle off", 32'(root_off_o), 1);

    // R3 directed commit timing
    wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd2, 32'h0000_01A5);
    wr(3'd3, 32'h0000_003C);
    wr(3'd4, 32'h0000_0077);
    chk_act("R2 staged not active");
    rd(3'd1, r); chk("R2 cfg mask", r, cfg_mask());
    rd(3'd2, r); chk("R2 m mask", r, 32'hA5);
    rd(3'd0, r); chk("R5 all dirty", r, 32'h8000_00F0);
    wr(3'd0, 32'h1);                       // captured at E0
    chk_act("R3 after E0 old");
    rd(3'd0, r); chk("R3 pending", r, 32'h8000_00F1);   // after E1
    chk_act("R3 after E1 old");
    rd(3'd0, r); chk("R3 still pending", r, 32'h8000_00F1);
    model_commit();
    chk_act("R3 after E2 new");
    rd(3'd0, r); chk("R3 R5 cleared", r, 32'h8000_0000);

    // R4 second request while pending
    wr(3'd2, 32'h11); wr(3'd3, 32'h22);
    wr(3'd0, 32'h1);                       // E0
    wr(3'd0, 32'h1);                       // E1 ignored
    rd(3'd0, r); chk("R4 pending at E1", r, 32'h8000_0061);
    model_commit();
    chk_act("R4 on schedule");
    rd(3'd0, r); chk("R4 cleared", r, 32'h8000_0000);
    wr(3'd4, 32'h99);
    repeat (4) @(negedge clk_i);
    chk_act("R4 no queued commit");
    rd(3'd0, r); chk("R4 no pending", r, 32'h8000_0080);

    // R8 write 0 while pending
    wr(3'd0, 32'h1);                       // E0
    wr(3'd0, 32'h0);                       // E1
    rd(3'd0, r); chk("R8 not cancelled", r, 32'h8000_0081);
    model_commit();
    chk_act("R8 applied");

    // random rounds
    for (int it = 0; it < 40; it++) begin
      logic [3:0] sel;
      logic [3:0] exp_dirty;
      sel = 4'($urandom_range(1, 15));
      exp_dirty = 0;
      if (sel[0]) begin wr(3'd1, $urandom); exp_dirty[0] = 1; end
      if (sel[1]) begin wr(3'd2, $urandom); exp_dirty[2] = 1; end
      if (sel[2]) begin wr(3'd3, $urandom); exp_dirty[1] = 1; end
      if (sel[3]) begin wr(3'd4, $urandom); exp_dirty[3] = 1; end
      chk_act("R2 random hold");
      rd(3'd1, r); chk("R2 random cfg", r, exp_cfg);
      rd(3'd3, r); chk("R2 random n", r, exp_n);
      rd(3'd0, r); chk("R5 random dirty", r, 32'h8000_0000 | (32'(exp_dirty) << 4));
      chk_act("R2 random hold late");
      wr(3'd0, 32'h1);
      @(negedge clk_i);
      chk_act("R3 random before");
      @(negedge clk_i);
      model_commit();
      chk_act("R3 random commit");
      rd(3'd0, r); chk("R5 random clear", r, 32'h8000_0000);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule